// File: doc/BRIEF.md
# EEPROM Page Buffer and Write Sequencer

This block sits behind the serial protocol controller of a small non-volatile memory. During a write transfer it gathers the incoming data bytes into a page latch of 32 bytes. It also keeps the internal address pointer that reads use. When the transfer ends with STOP, it copies the latched bytes into the storage array through a simple write port. It does this during a busy interval of fixed length, and ignores every other request until that interval is over.

The protocol controller gives the block a strobe for START, a strobe to load the pointer from the decoded word address, a strobe for each received data byte, and a strobe for each byte sent out on a read. It also gives a strobe for STOP. Two more inputs can veto a commit: the write-protect pin and a low-supply flag. The storage array lives outside the block, and the block only drives its write port. The pointer is 13 bits wide. Its upper 8 bits select the page and its lower 5 bits select the byte within the page.

Top module: `pagewr_top`

## Requirements
- R1: After reset, `busy` is 0, `curAddr` is 0 and `memWe` is 0.
- R2: Each `byteStrobe` stores `byteIn` into the latch slot that `curAddr[4:0]` selects. It then increments only `curAddr[4:0]`, so slot 31 is followed by slot 0, and `curAddr[12:5]` does not change.
- R3: When more than 32 bytes arrive in one transfer, a later byte that lands on a slot already used replaces the earlier byte. Only the latest value of that slot is committed.
- R4: `memWe` is never 1 before STOP, or at any time while `busy` is 0.
- R5: A STOP that may commit raises `busy` on the next clock. `busy` then stays 1 for exactly `WRITE_CYCLES` cycles.
- R6: During the busy interval, each slot that received a byte is written once, at address {`curAddr[12:5]`, slot}, with its latched byte. A slot that received no byte is never written.
- R7: If `wpIn` is 1 in any cycle from START through the STOP cycle, the STOP produces no busy interval and no write.
- R8: If `lowSupply` is 1 in the STOP cycle, the STOP produces no busy interval and no write.
- R9: A STOP after a transfer that held no data bytes produces no busy interval and no write.
- R10: Each `readAdvance` increments the full 13-bit `curAddr` by one, and 8191 wraps to 0.
- R11: While `busy` is 1, all strobes are ignored. `curAddr` does not change, and bytes offered during that time are never committed.
- R12: After a write transfer, `curAddr` equals the loaded address with its low 5 bits advanced by the byte count modulo 32.
- R13: `addrLoad` sets `curAddr` to `addrIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrobe | input | 1 | START seen; opens a transfer and clears the latch |
| stopStrobe | input | 1 | STOP seen; may start the commit |
| addrLoad | input | 1 | Load the pointer from `addrIn` |
| addrIn | input | 13 | Word address from the protocol controller |
| byteStrobe | input | 1 | One write data byte received |
| byteIn | input | 8 | Received data byte |
| readAdvance | input | 1 | One read byte sent out |
| wpIn | input | 1 | Write-protect pin, high protects |
| lowSupply | input | 1 | Supply below the safe write level |
| busy | output | 1 | Internal write interval in progress |
| curAddr | output | 13 | Current address pointer |
| memWe | output | 1 | Array write enable |
| memAddr | output | 13 | Array write address |
| memWdata | output | 8 | Array write data |

## Verification
The embedded properties are checked on every cycle. They cover the following rules:
- a byte never moves the page bits, and a read step adds exactly one;
- the pointer is frozen while busy;
- write enables appear only inside the busy interval, and the busy interval begins only just after a STOP;
- a protected or low-supply STOP never raises busy.

Other behaviours are shown only by the bench's transfers, which are checked against a model of the page. These are:
- which slots are written and with which bytes, including the overwrite of a wrapped slot;
- the exact length of the busy interval;
- the final pointer value;
- a protect pulse in the middle of a transfer;
- the fact that bytes offered while busy never appear later.

// File: rtl/pagewr_pkg.sv
package pagewr_pkg;
  typedef struct packed {
    logic busy;
    logic clearMask;
    logic loadAddr;
    logic latchByte;
    logic incRead;
    logic commitEn;
  } ctlStrobe_t;
endpackage

// File: rtl/pagewr_ctrl.sv
module pagewr_ctrl #(
  parameter int PAGE_W       = 5,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     startStrobe,
  input  logic                     stopStrobe,
  input  logic                     addrLoad,
  input  logic                     byteStrobe,
  input  logic                     readAdvance,
  input  logic                     wpIn,
  input  logic                     lowSupply,
  input  logic                     anyValid,
  output pagewr_pkg::ctlStrobe_t   ctl,
  output logic [PAGE_W-1:0]        commitSlot
);
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(WRITE_CYCLES + 1);

  logic             busyQ;
  logic [CNT_W-1:0] cycleCnt;
  logic             wpSeen;
  logic             goCommit;
  logic             lastCycle;

  assign goCommit  = !busyQ && stopStrobe && anyValid && !wpSeen && !wpIn && !lowSupply;
  assign lastCycle = busyQ && (cycleCnt == CNT_W'(WRITE_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      cycleCnt <= '0;
      wpSeen   <= 1'b0;
    end else if (busyQ) begin
      if (lastCycle) begin
        busyQ    <= 1'b0;
        cycleCnt <= '0;
      end else begin
        cycleCnt <= cycleCnt + 1'b1;
      end
    end else begin
      if (goCommit) begin
        busyQ    <= 1'b1;
        cycleCnt <= '0;
      end
      if (stopStrobe)       wpSeen <= 1'b0;
      else if (startStrobe) wpSeen <= wpIn;
      else                  wpSeen <= wpSeen | wpIn;
    end
  end

  always_comb begin
    ctl.busy      = busyQ;
    ctl.clearMask = (!busyQ && (startStrobe || (stopStrobe && !goCommit))) || lastCycle;
    ctl.loadAddr  = !busyQ && !stopStrobe && addrLoad;
    ctl.latchByte = !busyQ && !stopStrobe && !addrLoad && byteStrobe;
    ctl.incRead   = !busyQ && !stopStrobe && !addrLoad && !byteStrobe && readAdvance;
    ctl.commitEn  = busyQ && (cycleCnt < CNT_W'(PAGE_BYTES));
  end
  assign commitSlot = cycleCnt[PAGE_W-1:0];

  // R5: a busy interval only opens on the clock after a STOP
  p_busy_after_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyQ) |-> $past(stopStrobe));
  // R7: protect seen in the stop cycle blocks the commit
  p_wp_blocks_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && stopStrobe && wpIn) |=> !busyQ);
  // R8: low supply in the stop cycle blocks the commit
  p_low_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && stopStrobe && lowSupply) |=> !busyQ);
  // R5: the counter never runs past the interval length
  p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (cycleCnt < CNT_W'(WRITE_CYCLES)));
endmodule

// File: rtl/pagewr_dpath.sv
module pagewr_dpath #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pagewr_pkg::ctlStrobe_t ctl,
  input  logic [PAGE_W-1:0]      commitSlot,
  input  logic [ADDR_W-1:0]      addrIn,
  input  logic [DATA_W-1:0]      byteIn,
  output logic                   anyValid,
  output logic [ADDR_W-1:0]      curAddr,
  output logic                   memWe,
  output logic [ADDR_W-1:0]      memAddr,
  output logic [DATA_W-1:0]      memWdata
);
  localparam int PAGE_BYTES = 1 << PAGE_W;

  logic [DATA_W-1:0]     pageBuf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] validMask;
  logic [PAGE_W-1:0]     slotSel;

  assign slotSel = curAddr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (ctl.latchByte) pageBuf[slotSel] <= byteIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validMask <= '0;
      curAddr   <= '0;
    end else begin
      if (ctl.clearMask)      validMask <= '0;
      else if (ctl.latchByte) validMask[slotSel] <= 1'b1;

      if (ctl.loadAddr)       curAddr <= addrIn;
      else if (ctl.latchByte) curAddr <= {curAddr[ADDR_W-1:PAGE_W], PAGE_W'(slotSel + 1'b1)};
      else if (ctl.incRead)   curAddr <= curAddr + 1'b1;
    end
  end

  assign anyValid = |validMask;
  assign memWe    = ctl.commitEn && validMask[commitSlot];
  assign memAddr  = {curAddr[ADDR_W-1:PAGE_W], commitSlot};
  assign memWdata = pageBuf[commitSlot];

  // R2: storing a byte never moves the page bits
  p_page_keep_r2: assert property (@(posedge clk) disable iff (!rstN)
    ctl.latchByte |=> curAddr[ADDR_W-1:PAGE_W] == $past(curAddr[ADDR_W-1:PAGE_W]));
  // R10: a read step adds exactly one across the array
  p_read_step_r10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.incRead |=> curAddr == $past(curAddr) + 1'b1);
  // R11: pointer frozen through the busy interval
  p_hold_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.busy && $past(ctl.busy)) |-> $stable(curAddr));
  // R4: array writes only inside the busy interval
  p_we_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ctl.busy);
endmodule

// File: rtl/pagewr_top.sv
module pagewr_top #(
  parameter int ADDR_W       = 13,
  parameter int PAGE_W       = 5,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 625000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic              stopStrobe,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              byteStrobe,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              readAdvance,
  input  logic              wpIn,
  input  logic              lowSupply,
  output logic              busy,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  pagewr_pkg::ctlStrobe_t ctl;
  logic [PAGE_W-1:0]      commitSlot;
  logic                   anyValid;

  pagewr_ctrl #(.PAGE_W(PAGE_W), .WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .addrLoad(addrLoad), .byteStrobe(byteStrobe), .readAdvance(readAdvance),
    .wpIn(wpIn), .lowSupply(lowSupply), .anyValid(anyValid),
    .ctl(ctl), .commitSlot(commitSlot)
  );

  pagewr_dpath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .commitSlot(commitSlot),
    .addrIn(addrIn), .byteIn(byteIn), .anyValid(anyValid), .curAddr(curAddr),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  assign busy = ctl.busy;
endmodule

// File: tb/pagewr_top_bench.sv
module pagewr_top_bench;
  localparam int WC = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startStrobe = 0, stopStrobe = 0, addrLoad = 0, byteStrobe = 0;
  logic        readAdvance = 0, wpIn = 0, lowSupply = 0;
  logic [12:0] addrIn = '0;
  logic [7:0]  byteIn = '0;
  logic        busy, memWe;
  logic [12:0] curAddr, memAddr;
  logic [7:0]  memWdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pagewr_top #(.WRITE_CYCLES(WC)) u_pagewr_top (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe), .stopStrobe(stopStrobe),
    .addrLoad(addrLoad), .addrIn(addrIn), .byteStrobe(byteStrobe), .byteIn(byteIn),
    .readAdvance(readAdvance), .wpIn(wpIn), .lowSupply(lowSupply), .busy(busy),
    .curAddr(curAddr), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [12:0] expPtr(input logic [12:0] sa, input int n);
    return {sa[12:5], 5'(sa[4:0] + n)};
  endfunction

  function automatic bit expCommit(input int n, input int wpAt, input bit low, input bit wpStop);
    return (n > 0) && (wpAt < 0) && !low && !wpStop;
  endfunction

  task automatic doWrite(input logic [12:0] sa, input int n, input int wpAt,
                         input bit low, input bit wpStop, input bit inject);
    logic [7:0]  eBuf [32];
    logic [31:0] eMask = '0;
    bit          commit = expCommit(n, wpAt, low, wpStop);
    int          cyc = 0;
    int          bad = 0;
    @(negedge clk); startStrobe = 1;
    @(negedge clk); startStrobe = 0; addrLoad = 1; addrIn = sa;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      addrLoad = 0; byteStrobe = 1; byteIn = 8'($urandom);
      eBuf[5'(sa[4:0] + i)] = byteIn;
      eMask[5'(sa[4:0] + i)] = 1'b1;
      wpIn = (i == wpAt);
    end
    @(negedge clk);
    addrLoad = 0; byteStrobe = 0; wpIn = wpStop; lowSupply = low; stopStrobe = 1;
    chk(!memWe && !busy, "R4 no write before stop", memWe, 0);
    @(negedge clk); stopStrobe = 0; wpIn = 0; lowSupply = 0;
    chk(busy == commit, "R5/R7/R8/R9 busy after stop", busy, commit);
    if (commit) begin
      while (busy && cyc < 1000) begin
        if (memWe) begin
          chk(memAddr[12:5] == sa[12:5] && eMask[memAddr[4:0]] &&
              memWdata == eBuf[memAddr[4:0]], "R6/R3 committed byte",
              memWdata, eBuf[memAddr[4:0]]);
          eMask[memAddr[4:0]] = 1'b0;
        end
        if (inject && cyc == 3) begin
          byteStrobe = 1; readAdvance = 1; byteIn = 8'hA5;
        end else if (inject && cyc == 4) begin
          byteStrobe = 0; readAdvance = 0; addrLoad = 1; addrIn = ~sa;
        end else begin
          byteStrobe = 0; readAdvance = 0; addrLoad = 0;
        end
        cyc++;
        @(negedge clk);
      end
      chk(cyc == WC, "R5 busy length", cyc, WC);
      chk(eMask == 0, "R6 all received slots written", int'(eMask), 0);
    end else begin
      for (int k = 0; k < 4; k++) begin
        if (memWe || busy) bad++;
        @(negedge clk);
      end
      chk(bad == 0, "R7/R8/R9 no commit", bad, 0);
    end
    chk(curAddr == expPtr(sa, n), "R12/R11 pointer after write", curAddr, expPtr(sa, n));
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && curAddr == 0 && !memWe, "R1 reset state", curAddr, 0);
    rstN = 1;
    @(negedge clk);
    // R2 in-page wrap, R13 load
    doWrite(13'h0A3E, 5, -1, 0, 0, 0);
    // R3 overwrite past 32 bytes
    doWrite(13'h1F05, 40, -1, 0, 0, 0);
    // R7 protect pulse mid-transfer, and at the stop cycle
    doWrite(13'h0100, 6, 2, 0, 0, 0);
    doWrite(13'h0200, 3, -1, 0, 1, 0);
    // R8 low supply
    doWrite(13'h0300, 4, -1, 1, 0, 0);
    // R9 no data bytes
    doWrite(13'h0400, 0, -1, 0, 0, 0);
    // R11 strobes during busy are ignored
    doWrite(13'h0555, 7, -1, 0, 0, 1);
    @(negedge clk); stopStrobe = 1;
    @(negedge clk); stopStrobe = 0;
    chk(!busy, "R11 byte offered while busy not kept", busy, 0);
    // R10 read wrap, R13 load
    @(negedge clk); addrLoad = 1; addrIn = 13'd8190;
    @(negedge clk); addrLoad = 0;
    chk(curAddr == 13'd8190, "R13 load pointer", curAddr, 8190);
    for (int i = 0; i < 3; i++) begin
      readAdvance = 1;
      @(negedge clk);
      readAdvance = 0;
      chk(curAddr == 13'(8191 + i), "R10 read step", curAddr, int'(13'(8191 + i)));
    end
    for (int r = 0; r < 12; r++) begin
      doWrite(13'($urandom), 1 + int'($urandom % 40), -1, 0, 0, 0);
    end
    done = 1;
  end

  initial begin
    for (int t = 0; t < 150000 && !done; t++) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule